// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is a purely combinational datapath slice for an 8-bit processor core. It performs the bit-level operations on a single byte: the circular rotates, the rotates through carry, the three shifts, the nibble exchange, and the single-bit test, set and clear operations. It also provides the short accumulator-only rotate forms, which differ from the general rotates only in how they treat the zero flag.

The instruction decoder presents an operation code, the operand byte, a bit index for the single-bit operations, and the current flag byte. In the same cycle the unit returns the new byte, the next flag byte, and a write enable that tells the register file whether the result should be stored. Fetching the operand from memory and sequencing the instruction are left to the surrounding core.

Top module: `rsb_unit`

## Requirements
- R1: The flag byte holds Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Bits 3 to 0 of `flags_out` are always 0, whatever bits 3 to 0 of `flags_in` hold.
- R2: Codes 1 and 5 rotate right circular and codes 0 and 4 rotate left circular. The bit shifted out goes both into C and into the vacated end.
- R3: Codes 2 and 6 rotate left through carry and codes 3 and 7 rotate right through carry. The incoming C fills the vacated end and the bit shifted out becomes the new C.
- R4: The short accumulator forms, codes 0 to 3, force Z, N and H to 0 and set C from the bit shifted out.
- R5: The general rotate and shift forms, codes 4 to 10, set Z when the result is zero, clear N and H, and set C from the bit shifted out.
- R6: Code 8 shifts left and fills bit 0 with 0. Code 9 shifts right and keeps bit 7. Code 10 shifts right and fills bit 7 with 0. In all three the bit shifted out becomes C.
- R7: Code 11 exchanges the upper and lower nibbles, sets Z when the result is zero, and clears N, H and C.
- R8: Code 12 sets Z to the inverse of operand bit `bit_idx`, clears N, sets H and keeps C. `result` equals the operand.
- R9: Code 13 forces operand bit `bit_idx` to 1 and code 14 forces it to 0. The other bits are unchanged and the four flags are passed through from `flags_in`.
- R10: `result_we` is 1 for codes 0 to 11, 13 and 14, and 0 for codes 12 and 15.
- R11: Code 15 is a no-operation. `result` equals the operand and the flags are passed through from `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, 0 to 15 |
| operand | input | 8 | Operand byte |
| bit_idx | input | 3 | Bit position for codes 12 to 14 |
| flags_in | input | 8 | Current flags (Z,N,H,C in bits 7..4) |
| result | output | 8 | Resulting byte |
| flags_out | output | 8 | Next flags, low nibble zero |
| result_we | output | 1 | Result should be written back |

## Verification
The bench builds the unit with its default 8-bit data width, which keeps the input space small enough to sweep completely. It drives every operation code with every operand byte, every bit index and both carry-in values. The other three incoming flags and the unused low flag nibble follow operand-dependent patterns, so pass-through and masking behaviour are seen under many flag combinations. As a result, every fill bit, every carry-out, the zero result of every operation and every bit position of the test, set and clear operations are each observed at least once.

// File: rtl/rsb_pkg.sv
// Package: shared operation codes and flag bit positions for the
// rotate/shift/bit unit. Assumes an 8-bit flag byte with the four flags
// in the upper nibble.
package rsb_pkg;

    localparam int FLAG_W = 8;
    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;

    typedef enum logic [3:0] {
        OP_ACC_RLC = 4'd0,
        OP_ACC_RRC = 4'd1,
        OP_ACC_RL  = 4'd2,
        OP_ACC_RR  = 4'd3,
        OP_RLC     = 4'd4,
        OP_RRC     = 4'd5,
        OP_RL      = 4'd6,
        OP_RR      = 4'd7,
        OP_SHL     = 4'd8,
        OP_SAR     = 4'd9,
        OP_SHR     = 4'd10,
        OP_NSWAP   = 4'd11,
        OP_BTST    = 4'd12,
        OP_BSET    = 4'd13,
        OP_BCLR    = 4'd14,
        OP_NONE    = 4'd15
    } rsb_op_e;

endpackage

// File: rtl/rsb_shift.sv
// Module: rotate / shift / nibble-swap datapath.
// Produces the shifted byte and the bit shifted out for codes 0..11.
// Assumes DATA_W is even (for the half swap). Pure combinational.
module rsb_shift
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rsb_op_e           op,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output logic [DATA_W-1:0] dout,
    output logic              cout
);
    localparam int HALF = DATA_W / 2;

    logic msb, lsb;
    assign msb = din[DATA_W-1];
    assign lsb = din[0];

    // Select fill bit and carry-out per operation.
    always_comb begin
        dout = din;
        cout = 1'b0;
        unique case (op)
            OP_ACC_RLC, OP_RLC: begin dout = {din[DATA_W-2:0], msb}; cout = msb; end
            OP_ACC_RRC, OP_RRC: begin dout = {lsb, din[DATA_W-1:1]}; cout = lsb; end
            OP_ACC_RL,  OP_RL:  begin dout = {din[DATA_W-2:0], cin}; cout = msb; end
            OP_ACC_RR,  OP_RR:  begin dout = {cin, din[DATA_W-1:1]}; cout = lsb; end
            OP_SHL:             begin dout = {din[DATA_W-2:0], 1'b0}; cout = msb; end
            OP_SAR:             begin dout = {msb, din[DATA_W-1:1]}; cout = lsb; end
            OP_SHR:             begin dout = {1'b0, din[DATA_W-1:1]}; cout = lsb; end
            OP_NSWAP:           begin dout = {din[HALF-1:0], din[DATA_W-1:HALF]}; cout = 1'b0; end
            default:            begin dout = din; cout = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rsb_bitop.sv
// Module: single-bit test / set / clear datapath.
// Decodes the bit index into a one-hot mask and applies it. Assumes
// IDX_W = clog2(DATA_W). Pure combinational.
module rsb_bitop
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  rsb_op_e           op,
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] dout,
    output logic              bit_val
);
    logic [DATA_W-1:0] mask;

    // One comparator per bit position builds the one-hot mask.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (idx == IDX_W'(g));
    end

    assign bit_val = |(din & mask);

    // Apply the mask for set/clear; other codes pass the byte through.
    always_comb begin
        unique case (op)
            OP_BSET: dout = din | mask;
            OP_BCLR: dout = din & ~mask;
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/rsb_flagmux.sv
// Module: next-flag and write-enable generation.
// Combines the datapath result with the incoming flags according to the
// flag rule of each operation group. The low flag nibble is always zero.
module rsb_flagmux
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rsb_op_e           op,
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    input  logic              bit_val,
    input  logic [FLAG_W-1:0] fin,
    output logic [FLAG_W-1:0] fout,
    output logic              we
);
    logic res_zero;
    logic z, n, h, c;
    assign res_zero = (res == '0);

    // Choose the four flags for the operation's group.
    always_comb begin
        z = fin[FZ]; n = fin[FN]; h = fin[FH]; c = fin[FC];
        we = 1'b1;
        unique case (op)
            OP_ACC_RLC, OP_ACC_RRC, OP_ACC_RL, OP_ACC_RR: begin
                z = 1'b0; n = 1'b0; h = 1'b0; c = cout;
            end
            OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SHL, OP_SAR, OP_SHR: begin
                z = res_zero; n = 1'b0; h = 1'b0; c = cout;
            end
            OP_NSWAP: begin
                z = res_zero; n = 1'b0; h = 1'b0; c = 1'b0;
            end
            OP_BTST: begin
                z = ~bit_val; n = 1'b0; h = 1'b1; we = 1'b0;
            end
            OP_BSET, OP_BCLR: begin
                we = 1'b1;
            end
            default: begin
                we = 1'b0;
            end
        endcase
    end

    // Pack flags into the upper nibble; lower nibble reads as zero.
    assign fout = {z, n, h, c, 4'b0000};

endmodule

// File: rtl/rsb_unit.sv
// Module: top of the rotate/shift/bit unit.
// Routes the operand to the shift path or the bit path by operation code
// and generates flags and write enable. Fully combinational; assumes the
// caller registers the outputs.
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              result_we
);
    rsb_op_e           op;
    logic [DATA_W-1:0] sh_res, bt_res;
    logic              sh_cout, bt_val;

    assign op = rsb_op_e'(op_sel);

    rsb_shift #(.DATA_W(DATA_W)) u_shift (
        .op(op), .din(operand), .cin(flags_in[FC]),
        .dout(sh_res), .cout(sh_cout)
    );

    rsb_bitop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitop (
        .op(op), .din(operand), .idx(bit_idx),
        .dout(bt_res), .bit_val(bt_val)
    );

    // Pick the shift path for codes 0..11, the bit path otherwise.
    always_comb begin
        if (op_sel <= 4'd11) result = sh_res;
        else                 result = bt_res;
    end

    rsb_flagmux #(.DATA_W(DATA_W)) u_flags (
        .op(op), .res(result), .cout(sh_cout), .bit_val(bt_val),
        .fin(flags_in), .fout(flags_out), .we(result_we)
    );

endmodule

// File: rtl/rsb_unit_chk.sv
// Module: property checker for rsb_unit, attached by bind. Uses immediate
// assertions because the unit is combinational and has no clock.
module rsb_unit_chk
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] operand,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags_out,
    input logic              result_we
);
    // Evaluate all properties on every input change.
    always_comb begin
        p_low_nibble_r1: assert (flags_out[3:0] == 4'b0000)
            else $error("flag low nibble not zero");
        if (op_sel == 4'd0 || op_sel == 4'd1 || op_sel == 4'd4 || op_sel == 4'd5) begin
            p_ones_kept_r2: assert ($countones(result) == $countones(operand))
                else $error("circular rotate changed bit count");
        end
        if (op_sel <= 4'd3) begin
            p_acc_z_clear_r4: assert (flags_out[FZ] == 1'b0 && flags_out[FN] == 1'b0
                                      && flags_out[FH] == 1'b0)
                else $error("short rotate flags wrong");
        end
        if (op_sel >= 4'd4 && op_sel <= 4'd11) begin
            p_gen_z_r5: assert (flags_out[FZ] == (result == '0))
                else $error("general Z mismatch");
        end
        if (op_sel == 4'd11) begin
            p_swap_c_r7: assert (flags_out[FC] == 1'b0 && $countones(result) == $countones(operand))
                else $error("swap flags wrong");
        end
        if (op_sel == 4'd12) begin
            p_btst_nowrite_r8: assert (!result_we && result == operand
                                       && flags_out[FC] == flags_in[FC] && flags_out[FH])
                else $error("bit test wrote or changed flags");
        end
        if (op_sel == 4'd13 || op_sel == 4'd14) begin
            p_bitmod_flags_r9: assert (flags_out[7:4] == flags_in[7:4]
                                       && $countones(result ^ operand) <= 1)
                else $error("bit set/clear touched flags or other bits");
        end
        p_we_r10: assert (result_we == !(op_sel == 4'd12 || op_sel == 4'd15))
            else $error("write enable wrong");
    end

endmodule

bind rsb_unit rsb_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel(op_sel), .operand(operand), .bit_idx(bit_idx), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .result_we(result_we)
);

// File: tb/sim_rsb_unit.sv
// Bench: exhaustive sweep of rsb_unit over all codes, operands, bit
// indices and carry-in values, with an arithmetic reference model.
module sim_rsb_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = 4'd15;
    logic [7:0] operand = 8'd0;
    logic [2:0] bit_idx = 3'd0;
    logic [7:0] flags_in = 8'd0;
    logic [7:0] result;
    logic [7:0] flags_out;
    logic       result_we;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rsb_unit u0 (
        .op_sel(op_sel), .operand(operand), .bit_idx(bit_idx), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .result_we(result_we)
    );

    function automatic string req_of(int op);
        if (op <= 1) return "R2/R4";
        if (op <= 3) return "R3/R4";
        if (op == 4 || op == 5) return "R2/R5";
        if (op == 6 || op == 7) return "R3/R5";
        if (op <= 10) return "R6/R5";
        if (op == 11) return "R7";
        if (op == 12) return "R8";
        if (op <= 14) return "R9";
        return "R11";
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state right after reset: code 15, operand 0.
        @(negedge clk);
        op_sel = 4'd15; operand = 8'hA5; flags_in = 8'hBF;
        #1;
        check("R11 idle result", int'(result), 'hA5);
        check("R11 idle flags", int'(flags_out), 'hB0);
        check("R10 idle we", int'(result_we), 0);

        for (int op = 0; op < 16; op++) begin
            for (int idx = 0; idx < 8; idx++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int c = 0; c < 2; c++) begin
                        int zi, ni, hi, junk, r, co, z, n, h, cf, we, bit1;
                        zi = (a + idx) % 2;
                        ni = (a / 3) % 2;
                        hi = (a / 5) % 2;
                        junk = (a * 7 + idx) % 16;
                        bit1 = (a / (1 << idx)) % 2;
                        r = a; co = c; z = zi; n = ni; h = hi; cf = c; we = 1;
                        case (op)
                            0, 4: begin r = (a * 2) % 256 + a / 128; co = a / 128; end
                            1, 5: begin r = a / 2 + (a % 2) * 128;   co = a % 2;   end
                            2, 6: begin r = (a * 2) % 256 + c;       co = a / 128; end
                            3, 7: begin r = a / 2 + c * 128;         co = a % 2;   end
                            8:    begin r = (a * 2) % 256;           co = a / 128; end
                            9:    begin r = a / 2 + (a / 128) * 128; co = a % 2;   end
                            10:   begin r = a / 2;                   co = a % 2;   end
                            11:   begin r = (a % 16) * 16 + a / 16;  co = 0;       end
                            12:   begin r = a; we = 0; end
                            13:   r = (bit1 == 1) ? a : a + (1 << idx);
                            14:   r = (bit1 == 1) ? a - (1 << idx) : a;
                            default: we = 0;
                        endcase
                        if (op <= 3) begin z = 0; n = 0; h = 0; cf = co; end
                        else if (op <= 11) begin z = (r == 0) ? 1 : 0; n = 0; h = 0; cf = co; end
                        else if (op == 12) begin z = 1 - bit1; n = 0; h = 1; cf = c; end
                        @(negedge clk);
                        op_sel = 4'(op);
                        operand = 8'(a);
                        bit_idx = 3'(idx);
                        flags_in = 8'(zi * 128 + ni * 64 + hi * 32 + c * 16 + junk);
                        #1;
                        check(req_of(op), int'(result), r);
                        check(req_of(op), int'(flags_out[7:4]), z * 8 + n * 4 + h * 2 + cf);
                        check("R1 low nibble", int'(flags_out[3:0]), 0);
                        check("R10 write enable", int'(result_we), we);
                    end
                end
            end
        end
        finish_run();
    end

endmodule